// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is one general-purpose timer channel. It takes three tick-enable inputs from the system clock domain: a low-speed oscillator tick, a main oscillator tick and an external clock tick. A source field picks one of them, and a power-of-two prescaler divides the chosen ticks. In normal mode the channel loads an interval value and counts down once per prescaled tick. When it reaches zero it raises a single-cycle expiry pulse and stops. When the external source is selected, the channel instead counts up from zero, ignores the interval and never expires.

Software drives the block through two write ports: a control word and an interval word. It reads the control word, the interval and the live count back as plain outputs. Clearing the enable bit pauses the count and setting it again resumes from the frozen value. Setting the reload bit together with enable restarts the count from the current interval. After a disable, a re-enable only takes effect once two prescaled ticks have passed.

Control word layout (bit positions): bit 0 enable, bit 1 reload, bits 3:2 source, bits 4 and up prescale exponent.

Top module: `pit_timer`

## Requirements
- R1: After reset the control readback shows source 01, prescale 000, reload 0 and enable 0. The count, the interval and the expiry output are all zero.
- R2: With prescale exponent p, the count moves once every 2^p selected source ticks. The divider restarts at each start, so the first decrement comes 2^p source ticks after the start edge.
- R3: Source code 00 counts on the low-speed tick, 01 on the main tick and 10 on the external tick. Code 11 never counts.
- R4: A start from idle or after expiry copies the interval into the count on the edge after the enabling write, and the count then decrements toward zero.
- R5: The decrement that brings the count to zero asserts expire_o for exactly one cycle. On that cycle the count reads 0, the enable bit reads back 0 and counting stops.
- R6: Clearing enable freezes the count. Setting enable again, without reload, resumes the decrement from the frozen value.
- R7: Rewriting the interval while paused changes the interval readback but not the frozen count, and a plain resume keeps the frozen count.
- R8: Writing reload=1 together with enable=1 restarts the count from the interval value held at that time.
- R9: The reload bit clears itself: it reads 1 right after the write and 0 once the reload has been applied.
- R10: With source 10, a start with reload (or from idle) loads 0. Each prescaled external tick then adds 1, the interval is ignored and expire_o stays low.
- R11: A re-enable written less than two prescaled ticks after a disable is held off. The count stays frozen until two prescaled ticks of the selected source have passed, and counting resumes after that.
- R12: An interval of 0 expires on the first prescaled tick after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lo_tick_i | input | 1 | Low-speed oscillator tick enable |
| main_tick_i | input | 1 | Main oscillator tick enable |
| ext_tick_i | input | 1 | External clock tick enable |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | PSC_W+4 | Control word write data |
| ival_wr_i | input | 1 | Interval write strobe |
| ival_wdata_i | input | CNT_W | Interval write data |
| ctl_o | output | PSC_W+4 | Control word readback |
| ival_o | output | CNT_W | Interval readback |
| count_o | output | CNT_W | Current counter value |
| expire_o | output | 1 | One-cycle pulse when the down-count reaches zero |

## Verification
The bench builds the block with an 8-bit counter, a 3-bit prescale field (division from 1 to 128) and a hold-off of two ticks. With these values it can sweep every prescale setting against intervals of 0, 1, 2 and 5 and check each expiry cycle against the product of interval and period. The short counter also keeps every run within a few hundred cycles. Because the bench drives the tick inputs by hand, it can place disable, rewrite, re-enable and the hold-off ticks on chosen cycles.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [1:0] {
      SRC_LOW  = 2'b00,
      SRC_MAIN = 2'b01,
      SRC_EXT  = 2'b10,
      SRC_OFF  = 2'b11
   } pit_src_e;

   localparam int unsigned EN_POS  = 0;
   localparam int unsigned RLD_POS = 1;
   localparam int unsigned SRC_POS = 2;
   localparam int unsigned PSC_POS = 4;
   localparam int unsigned N_SRC   = 4;

endpackage

// File: rtl/pit_src_mux.sv
module pit_src_mux
   import pit_pkg::*;
(
   input  pit_src_e sel_i,
   input  logic     lo_i,
   input  logic     main_i,
   input  logic     ext_i,
   output logic     tick_o,
   output logic     up_mode_o
);

   logic [N_SRC-1:0] cand;

   for (genvar g = 0; g < N_SRC; g++) begin : g_cand
      if (g == int'(SRC_LOW)) begin : g_lo
         assign cand[g] = lo_i;
      end else if (g == int'(SRC_MAIN)) begin : g_main
         assign cand[g] = main_i;
      end else if (g == int'(SRC_EXT)) begin : g_ext
         assign cand[g] = ext_i;
      end else begin : g_off
         assign cand[g] = 1'b0;
      end
   end

   assign tick_o    = cand[sel_i];
   assign up_mode_o = (sel_i == SRC_EXT);

endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int unsigned PSC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [PSC_W-1:0] psc_i,
   output logic             tick_o
);

   localparam int unsigned DIV_W = (1 << PSC_W) - 1;

   if (PSC_W < 1 || PSC_W > 5) begin : g_bad_psc
      $error("pit_prescaler: PSC_W must lie in 1..5");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] lim;

   assign lim    = DIV_W'((32'd1 << psc_i) - 32'd1);
   assign tick_o = tick_i && (div_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (clr_i) begin
         div_q <= '0;
      end else if (tick_i) begin
         div_q <= tick_o ? '0 : div_q + 1'b1;
      end
   end

endmodule

// File: rtl/pit_holdoff.sv
module pit_holdoff #(
   parameter int unsigned HOLD_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic tick_i,
   output logic ready_o
);

   localparam int unsigned HW = $clog2(HOLD_TICKS + 1);

   if (HOLD_TICKS < 1) begin : g_bad_hold
      $error("pit_holdoff: HOLD_TICKS must be at least 1");
   end

   logic [HW-1:0] gap_q;

   assign ready_o = (gap_q == HW'(HOLD_TICKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= HW'(HOLD_TICKS);
      end else if (arm_i) begin
         gap_q <= '0;
      end else if (tick_i && !ready_o) begin
         gap_q <= gap_q + 1'b1;
      end
   end

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             step_i,
   input  logic             up_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o
);

   logic [CNT_W-1:0] cnt_q;

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q[CNT_W-1:1] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (step_i) begin
         if (up_i) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (last_o) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
   import pit_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned PSC_W      = 3,
   parameter int unsigned HOLD_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_tick_i,
   input  logic             main_tick_i,
   input  logic             ext_tick_i,
   input  logic             ctl_wr_i,
   input  logic [PSC_W+3:0] ctl_wdata_i,
   input  logic             ival_wr_i,
   input  logic [CNT_W-1:0] ival_wdata_i,
   output logic [PSC_W+3:0] ctl_o,
   output logic [CNT_W-1:0] ival_o,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   localparam int unsigned CTL_W = PSC_W + 4;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("pit_timer: CNT_W must lie in 2..32");
   end

   logic             en_q;
   logic             rld_q;
   pit_src_e         src_q;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] ival_q;
   logic             run_q;
   logic             armed_q;
   logic             expire_q;

   logic             src_tick;
   logic             up_mode;
   logic             pre_tick;
   logic             hold_ready;
   logic             active;
   logic             start;
   logic             load;
   logic             step;
   logic             fire;
   logic             cnt_last;
   logic             disable_ev;
   logic [CNT_W-1:0] load_val;

   assign active     = run_q & en_q;
   assign start      = en_q & ~run_q & hold_ready;
   assign load       = (start & (~armed_q | rld_q)) | (active & rld_q);
   assign step       = active & pre_tick & ~load;
   assign fire       = step & ~up_mode & cnt_last;
   assign disable_ev = ctl_wr_i & ~ctl_wdata_i[EN_POS] & en_q;
   assign load_val   = up_mode ? '0 : ival_q;

   pit_src_mux u_mux (
      .sel_i     (src_q),
      .lo_i      (lo_tick_i),
      .main_i    (main_tick_i),
      .ext_i     (ext_tick_i),
      .tick_o    (src_tick),
      .up_mode_o (up_mode)
   );

   pit_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (start | (active & rld_q)),
      .tick_i (src_tick),
      .psc_i  (psc_q),
      .tick_o (pre_tick)
   );

   pit_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (disable_ev),
      .tick_i  (pre_tick & ~active),
      .ready_o (hold_ready)
   );

   pit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .step_i     (step),
      .up_i       (up_mode),
      .cnt_o      (count_o),
      .last_o     (cnt_last)
   );

   // control word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         rld_q <= 1'b0;
         src_q <= SRC_MAIN;
         psc_q <= '0;
      end else if (ctl_wr_i) begin
         en_q  <= ctl_wdata_i[EN_POS];
         rld_q <= ctl_wdata_i[RLD_POS];
         src_q <= pit_src_e'(ctl_wdata_i[SRC_POS +: 2]);
         psc_q <= ctl_wdata_i[PSC_POS +: PSC_W];
      end else begin
         if (fire) en_q  <= 1'b0;
         if (load) rld_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ival_q <= '0;
      end else if (ival_wr_i) begin
         ival_q <= ival_wdata_i;
      end
   end

   // run state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         armed_q  <= 1'b0;
         expire_q <= 1'b0;
      end else begin
         run_q    <= (run_q | start) & en_q & ~fire;
         expire_q <= fire;
         if (fire) begin
            armed_q <= 1'b0;
         end else if (start) begin
            armed_q <= 1'b1;
         end
      end
   end

   always_comb begin
      ctl_o                     = '0;
      ctl_o[EN_POS]             = en_q;
      ctl_o[RLD_POS]            = rld_q;
      ctl_o[SRC_POS +: 2]       = src_q;
      ctl_o[PSC_POS +: PSC_W]   = psc_q;
   end

   assign ival_o   = ival_q;
   assign expire_o = expire_q;

   if (CTL_W != PSC_POS + PSC_W) begin : g_bad_layout
      $error("pit_timer: control layout mismatch");
   end

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
   import pit_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PSC_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr_i,
   input logic [PSC_W+3:0] ctl_o,
   input logic [CNT_W-1:0] count_o,
   input logic             expire_o
);

   p_expire_single_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !expire_o);

   p_expire_at_zero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> (count_o == '0));

   p_expire_drops_en_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !$past(ctl_wr_i)) |-> !ctl_o[EN_POS]);

   p_pause_freeze_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_o[EN_POS] |=> $stable(count_o));

   p_ext_no_expiry_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[SRC_POS +: 2] == 2'b10 && $past(ctl_o[SRC_POS +: 2]) == 2'b10) |-> !expire_o);

endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_pit_timer_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_wr_i (ctl_wr_i),
   .ctl_o    (ctl_o),
   .count_o  (count_o),
   .expire_o (expire_o)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;
   localparam int PSC_W      = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lo_tick = 1'b0;
   logic             main_tick = 1'b0;
   logic             ext_tick = 1'b0;
   logic             ctl_wr = 1'b0;
   logic [PSC_W+3:0] ctl_wdata = '0;
   logic             ival_wr = 1'b0;
   logic [CNT_W-1:0] ival_wdata = '0;
   logic [PSC_W+3:0] ctl_rd;
   logic [CNT_W-1:0] ival_rd;
   logic [CNT_W-1:0] count;
   logic             expire;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pit_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .HOLD_TICKS(2)) i_pit_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .lo_tick_i    (lo_tick),
      .main_tick_i  (main_tick),
      .ext_tick_i   (ext_tick),
      .ctl_wr_i     (ctl_wr),
      .ctl_wdata_i  (ctl_wdata),
      .ival_wr_i    (ival_wr),
      .ival_wdata_i (ival_wdata),
      .ctl_o        (ctl_rd),
      .ival_o       (ival_rd),
      .count_o      (count),
      .expire_o     (expire)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [PSC_W+3:0] cv(int p, int s, bit r, bit e);
      return {PSC_W'(p), 2'(s), r, e};
   endfunction

   task automatic wr_ctl(input logic [PSC_W+3:0] v);
      @(negedge clk);
      ctl_wr    = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_wr    = 1'b0;
   endtask

   task automatic wr_ival(input int v);
      @(negedge clk);
      ival_wr    = 1'b1;
      ival_wdata = CNT_W'(v);
      @(negedge clk);
      ival_wr    = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_main(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); main_tick = 1'b1;
         @(negedge clk); main_tick = 1'b0;
      end
   endtask

   task automatic pulse_ext(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_tick = 1'b1;
         chk("R10 no expiry in external mode", expire, 0);
         @(negedge clk); ext_tick = 1'b0;
         chk("R10 no expiry in external mode", expire, 0);
      end
   endtask

   task automatic pulse_lo(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); lo_tick = 1'b1;
         @(negedge clk); lo_tick = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 control readback", ctl_rd, cv(0, 1, 0, 0));
      chk("R1 count", count, 0);
      chk("R1 interval", ival_rd, 0);
      chk("R1 expiry", expire, 0);

      // R2 R4 R5 R12 sweep over every prescale value
      main_tick = 1'b1;
      for (int p = 0; p < 8; p++) begin
         for (int j = 0; j < 4; j++) begin
            int n;
            int m;
            int k;
            n = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 2 : 5;
            m = (n == 0) ? 1 : n;
            k = 0;
            wr_ival(n);
            wr_ctl(cv(p, 1, 0, 1));
            while (!expire && k < 2000) begin
               @(negedge clk);
               k++;
               if (k == (1 << p)) chk("R4 loaded interval before first tick", count, n);
               if (k == (1 << p) + 1 && n >= 2) chk("R2 first decrement", count, n - 1);
            end
            if (n == 0) chk("R12 zero interval expiry cycle", k, 1 + (1 << p));
            else        chk("R2 R4 expiry cycle", k, 1 + m * (1 << p));
            chk("R5 count zero at expiry", count, 0);
            chk("R5 enable cleared at expiry", ctl_rd[0], 0);
            @(negedge clk);
            chk("R5 single cycle pulse", expire, 0);
         end
      end
      main_tick = 1'b0;

      // R6 R7 R11 pause, rewrite and hold-off
      wr_ival(20);
      wr_ctl(cv(0, 1, 0, 1));
      idle(2);
      pulse_main(5);
      chk("R4 count after five ticks", count, 15);
      wr_ctl(cv(0, 1, 0, 0));
      idle(5);
      chk("R6 count frozen while paused", count, 15);
      wr_ival(50);
      chk("R7 interval readback", ival_rd, 50);
      chk("R7 frozen count kept", count, 15);
      wr_ctl(cv(0, 1, 0, 1));
      idle(8);
      chk("R11 early re-enable held off", count, 15);
      pulse_main(1);
      chk("R11 held after one tick", count, 15);
      pulse_main(1);
      idle(2);
      chk("R6 R7 resume keeps frozen value", count, 15);
      pulse_main(3);
      chk("R6 R11 counting resumed", count, 12);

      // R8 R9 reload with enable
      wr_ctl(cv(0, 1, 0, 0));
      pulse_main(2);
      wr_ival(40);
      wr_ctl(cv(0, 1, 1, 1));
      chk("R9 reload reads one after write", ctl_rd[1], 1);
      idle(2);
      chk("R8 restart from new interval", count, 40);
      chk("R9 reload self-cleared", ctl_rd[1], 0);
      pulse_main(4);
      chk("R8 decrement after reload", count, 36);

      // R10 external up-count
      wr_ctl(cv(0, 1, 0, 0));
      pulse_main(2);
      wr_ctl(cv(1, 2, 1, 1));
      idle(2);
      chk("R10 up count starts at zero", count, 0);
      pulse_ext(6);
      chk("R10 up count with prescale two", count, 3);
      chk("R10 interval ignored", ival_rd, 40);

      // R3 reserved source and low-speed source
      wr_ctl(cv(1, 2, 0, 0));
      pulse_ext(4);
      wr_ctl(cv(0, 3, 1, 1));
      idle(2);
      chk("R3 reserved source start loads interval", count, 40);
      main_tick = 1'b1; lo_tick = 1'b1; ext_tick = 1'b1;
      idle(10);
      main_tick = 1'b0; lo_tick = 1'b0; ext_tick = 1'b0;
      chk("R3 reserved source never counts", count, 40);
      wr_ctl(cv(0, 0, 0, 0));
      main_tick = 1'b1;
      pulse_lo(2);
      wr_ctl(cv(0, 0, 1, 1));
      idle(4);
      chk("R3 low-speed source ignores main tick", count, 40);
      pulse_lo(3);
      chk("R3 low-speed source counts", count, 37);
      main_tick = 1'b0;

      idle(2);
      finish_run();
   end

endmodule